// File: doc/BRIEF.md
# SIMD Add/Subtract High-Narrow Unit

This unit is a vector datapath stage that combines two 128-bit source vectors lane by lane. Each source lane is twice as wide as the result element. The unit adds or subtracts each pair of lanes, can optionally add a rounding bias of half a result LSB, and then keeps only the upper half of each wide result. The narrowed lanes form a 64-bit packed value. That value is written into either the lower or the upper half of a 128-bit destination.

A request is a one-cycle pulse on `in_valid`. It carries both sources, the previous destination contents, a two-bit size code and the operation controls. The new destination value appears one clock later, together with an `out_valid` pulse. A size code that asks for 64-bit result elements has no legal meaning. For that code the unit raises an error flag next to `out_valid` and passes the previous destination through unchanged. Every source lane is consumed before anything is written, so the result is correct when the destination register is also a source.

Top module: `simd_hnarrow_unit`

## Requirements
- R1: The size code sets the lane geometry. Code 0 gives 8 lanes with 8-bit results from 16-bit source lanes, code 1 gives 4 lanes of 16 from 32, and code 2 gives 2 lanes of 32 from 64. Source lane i occupies bits [i*2N +: 2N] and narrowed lane i occupies bits [i*N +: N] of the packed 64-bit value.
- R2: Size code 3 is illegal. It sets `size_err` to 1 in the cycle of `out_valid`, and `dst_new` then equals the `dst_old` that came with the request.
- R3: When `sub_en`=0 and `round_en`=0, each narrowed lane is bits [2N-1:N] of (a+b) mod 2^(2N).
- R4: When `sub_en`=1, each narrowed lane is bits [2N-1:N] of (a-b) mod 2^(2N).
- R5: When `round_en`=1, 2^(N-1) is added to the wide sum or difference before the high half is taken. Any carry out of the 2N-bit lane is discarded.
- R6: When `upper_sel`=0, the packed lanes land in `dst_new[63:0]` and `dst_new[127:64]` is zero.
- R7: When `upper_sel`=1, the packed lanes land in `dst_new[127:64]` and `dst_new[63:0]` equals `dst_old[63:0]`.
- R8: `out_valid` is high exactly one cycle after each cycle in which `in_valid` is high. `size_err` is never high without `out_valid`.
- R9: In a cycle without `in_valid`, `dst_new` holds its value.
- R10: After reset, `out_valid`, `size_err` and `dst_new` are all zero.
- R11: The result is correct when `dst_old` carries the same value as one of the sources.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| in_valid | input | 1 | Request pulse |
| src_a | input | 128 | First source vector (minuend) |
| src_b | input | 128 | Second source vector (subtrahend) |
| dst_old | input | 128 | Previous destination contents |
| size | input | 2 | Result element size code (0: 8, 1: 16, 2: 32, 3: illegal) |
| sub_en | input | 1 | 1 selects subtract, 0 selects add |
| round_en | input | 1 | 1 adds the half-LSB rounding bias |
| upper_sel | input | 1 | 1 writes the upper destination half |
| out_valid | output | 1 | Result pulse, one cycle after the request |
| dst_new | output | 128 | New destination value |
| size_err | output | 1 | Illegal size code reported with out_valid |

## Verification
On every cycle, the assertions check the request-to-result pulse timing and the pairing of `size_err` with `out_valid`. They also check the pass-through on an illegal size, the zeroed upper half, the preserved lower half, and that the output holds between requests. Only the bench scenarios can show the arithmetic values of the lanes. The bench compares them with an independent model across all three sizes, all four operations, borrow and carry wrap, and a rounding carry that leaves the lane. It also covers aliasing of the destination with a source.

// File: rtl/hn_pkg.sv
// Shared types and constants for the high-narrow unit.
// Assumes a 128-bit vector and three legal element sizes.
package hn_pkg;
    localparam int VEC_W     = 128;
    localparam int HALF_W    = VEC_W / 2;
    localparam int NUM_SIZES = 3;

    typedef enum logic [1:0] {
        SZ_BYTE = 2'd0,
        SZ_HALF = 2'd1,
        SZ_WORD = 2'd2,
        SZ_BAD  = 2'd3
    } size_e;
endpackage

// File: rtl/hn_lane.sv
// One wide lane: add or subtract, optional half-LSB bias, keep the high half.
// Assumes the wide lane is 2*NW bits and wraps modulo 2^(2*NW).
module hn_lane #(
    parameter int NW = 8
) (
    input  logic [2*NW-1:0] a,
    input  logic [2*NW-1:0] b,
    input  logic            sub,
    input  logic            rnd,
    output logic [NW-1:0]   hi
);
    localparam int WW = 2 * NW;

    logic [WW-1:0] wide;
    logic [WW-1:0] bias;

    // Form the wrapped wide result and take its upper half.
    always_comb begin
        bias = rnd ? ({{(WW-1){1'b0}}, 1'b1} << (NW - 1)) : '0;
        wide = (sub ? (a - b) : (a + b)) + bias;
        hi   = wide[WW-1:NW];
    end
endmodule

// File: rtl/hn_pack.sv
// Picks the packed narrow value for the size code and places it in a half.
// Assumes one 64-bit packed value per legal size.
module hn_pack
    import hn_pkg::*;
(
    input  size_e              size,
    input  logic               upper,
    input  logic [HALF_W-1:0]  n_byte,
    input  logic [HALF_W-1:0]  n_half,
    input  logic [HALF_W-1:0]  n_word,
    input  logic [VEC_W-1:0]   old_val,
    output logic [VEC_W-1:0]   new_val
);
    logic [HALF_W-1:0] sel;

    // Choose the narrowed set by size, then place it in the chosen half.
    always_comb begin
        case (size)
            SZ_BYTE: sel = n_byte;
            SZ_HALF: sel = n_half;
            SZ_WORD: sel = n_word;
            default: sel = '0;
        endcase
        if (upper)
            new_val = {sel, old_val[HALF_W-1:0]};
        else
            new_val = {{HALF_W{1'b0}}, sel};
    end
endmodule

// File: rtl/simd_hnarrow_unit.sv
// Top of the add/subtract high-narrow unit. Holds one register stage.
// Assumes the inputs are valid only in cycles where in_valid is high.
// All lanes are computed from the inputs together, so dst_old may equal a source.
module simd_hnarrow_unit
    import hn_pkg::*;
(
    input  logic          clk,
    input  logic          rst_n,
    input  logic          in_valid,
    input  logic [127:0]  src_a,
    input  logic [127:0]  src_b,
    input  logic [127:0]  dst_old,
    input  logic [1:0]    size,
    input  logic          sub_en,
    input  logic          round_en,
    input  logic          upper_sel,
    output logic          out_valid,
    output logic [127:0]  dst_new,
    output logic          size_err
);
    logic [HALF_W-1:0] narrow [NUM_SIZES];
    logic [VEC_W-1:0]  packed_res;
    size_e             size_q;
    logic              bad_size;

    assign size_q   = size_e'(size);
    assign bad_size = (size_q == SZ_BAD);

    // One lane array per legal element size.
    for (genvar s = 0; s < NUM_SIZES; s++) begin : g_size
        localparam int NW    = 8 << s;
        localparam int LANES = HALF_W / NW;
        logic [HALF_W-1:0] packed_n;
        for (genvar l = 0; l < LANES; l++) begin : g_lane
            hn_lane #(.NW(NW)) u_lane (
                .a   (src_a[l*2*NW +: 2*NW]),
                .b   (src_b[l*2*NW +: 2*NW]),
                .sub (sub_en),
                .rnd (round_en),
                .hi  (packed_n[l*NW +: NW])
            );
        end
        assign narrow[s] = packed_n;
    end

    hn_pack u_pack (
        .size    (size_q),
        .upper   (upper_sel),
        .n_byte  (narrow[0]),
        .n_half  (narrow[1]),
        .n_word  (narrow[2]),
        .old_val (dst_old),
        .new_val (packed_res)
    );

    // Result register: capture on request, pass old value through on bad size.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            out_valid <= 1'b0;
            size_err  <= 1'b0;
            dst_new   <= '0;
        end else begin
            out_valid <= in_valid;
            size_err  <= in_valid && bad_size;
            if (in_valid)
                dst_new <= bad_size ? dst_old : packed_res;
        end
    end

    // R8
    valid_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        in_valid |=> out_valid);
    // R8
    valid_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !in_valid |=> !out_valid);
    // R8
    err_with_valid_chk: assert property (@(posedge clk) disable iff (!rst_n)
        size_err |-> out_valid);
    // R2
    bad_size_pass_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && size == 2'd3) |=> (size_err && dst_new == $past(dst_old)));
    // R6
    low_half_zero_top_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && size != 2'd3 && !upper_sel) |=> (dst_new[127:64] == '0));
    // R7
    upper_keeps_low_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && size != 2'd3 && upper_sel) |=> (dst_new[63:0] == $past(dst_old[63:0])));
    // R9
    hold_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !in_valid |=> $stable(dst_new));
endmodule

// File: tb/tb_simd_hnarrow_unit.sv
`timescale 1ns/1ps
module tb_simd_hnarrow_unit;
    logic         clk = 1'b0;
    logic         rst_n;
    logic         in_valid;
    logic [127:0] src_a, src_b, dst_old;
    logic [1:0]   size;
    logic         sub_en, round_en, upper_sel;
    logic         out_valid, size_err;
    logic [127:0] dst_new;

    int  n_tests = 0;
    int  n_fail  = 0;
    bit  done    = 1'b0;

    always #4 clk = ~clk;

    simd_hnarrow_unit dut (
        .clk(clk), .rst_n(rst_n), .in_valid(in_valid),
        .src_a(src_a), .src_b(src_b), .dst_old(dst_old),
        .size(size), .sub_en(sub_en), .round_en(round_en), .upper_sel(upper_sel),
        .out_valid(out_valid), .dst_new(dst_new), .size_err(size_err)
    );

    // Independent model of the requirements R1, R3-R7.
    function automatic logic [127:0] model(input logic [127:0] a, input logic [127:0] b,
                                           input logic [127:0] old, input int sz,
                                           input bit sb, input bit rn, input bit up);
        logic [63:0]  packed_v = '0;
        int nw    = 8 << sz;
        int lanes = 8 >> sz;
        logic [63:0] wmask = (nw == 32) ? 64'hFFFF_FFFF_FFFF_FFFF : ((64'd1 << (2*nw)) - 1);
        logic [63:0] nmask = (64'd1 << nw) - 1;
        for (int i = 0; i < lanes; i++) begin
            logic [63:0] la = (a >> (i*2*nw)) & wmask;
            logic [63:0] lb = (b >> (i*2*nw)) & wmask;
            logic [63:0] w  = sb ? la - lb : la + lb;
            if (rn) w = w + (64'd1 << (nw-1));
            w = w & wmask;
            packed_v = packed_v | (((w >> nw) & nmask) << (i*nw));
        end
        return up ? {packed_v, old[63:0]} : {64'd0, packed_v};
    endfunction

    task automatic check(input string req, input logic [127:0] act, input logic [127:0] exp);
        n_tests++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    // Drive one request and check the registered result one cycle later.
    task automatic run_op(input string req, input logic [127:0] a, input logic [127:0] b,
                          input logic [127:0] old, input int sz, input bit sb,
                          input bit rn, input bit up);
        logic [127:0] exp;
        @(negedge clk);
        src_a = a; src_b = b; dst_old = old; size = 2'(sz);
        sub_en = sb; round_en = rn; upper_sel = up; in_valid = 1'b1;
        @(negedge clk);
        in_valid = 1'b0;
        exp = (sz == 3) ? old : model(a, b, old, sz, sb, rn, up);
        check({req, " R8 valid"}, {127'd0, out_valid}, 128'd1);
        check({req, " R2 err"}, {127'd0, size_err}, {127'd0, (sz == 3)});
        check({req, " data"}, dst_new, exp);
    endtask

    task automatic t_reset;
        check("R10 out_valid", {127'd0, out_valid}, 128'd0);
        check("R10 size_err", {127'd0, size_err}, 128'd0);
        check("R10 dst_new", dst_new, 128'd0);
    endtask

    task automatic t_add_sizes;
        for (int s = 0; s < 3; s++)
            run_op("R1 R3 add", 128'h0123_4567_89AB_CDEF_FEDC_BA98_7654_3210,
                   128'h1111_2222_3333_4444_5555_6666_7777_8888, '1, s, 0, 0, 0);
    endtask

    task automatic t_sub_borrow;
        for (int s = 0; s < 3; s++)
            run_op("R4 sub borrow", 128'h0001_0000_0000_0005_0000_0000_0000_0003,
                   128'h0002_0001_0000_0007_0000_0001_0000_0004, '0, s, 1, 0, 0);
    endtask

    task automatic t_round;
        // 0xFFFF + 0 + 0x80 wraps to 0x007F: high byte 0, carry dropped.
        run_op("R5 round carry", {8{16'hFFFF}}, '0, '0, 0, 0, 1, 0);
        check("R5 wrap value", dst_new, 128'd0);
        run_op("R5 round 0x80", {8{16'h0080}}, '0, '0, 0, 0, 1, 0);
        check("R5 rounded up", dst_new, {64'd0, {8{8'h01}}});
        for (int s = 0; s < 3; s++)
            run_op("R5 rsub", 128'h8000_7FFF_0000_0080_1234_0000_0000_0001,
                   128'h0000_0001_0000_0001_0034_0001_0000_0002, '0, s, 1, 1, 0);
    endtask

    task automatic t_halves;
        run_op("R6 low half", {16{8'hA5}}, {16{8'h3C}}, {16{8'hEE}}, 1, 0, 0, 0);
        run_op("R7 upper half", {16{8'hA5}}, {16{8'h3C}},
               128'h5555_5555_5555_5555_CAFE_F00D_1234_5678, 2, 1, 0, 1);
        check("R7 low kept", {64'd0, dst_new[63:0]}, {64'd0, 64'hCAFE_F00D_1234_5678});
    endtask

    task automatic t_illegal;
        run_op("R2 illegal", {8{16'h1234}}, {8{16'h4321}}, 128'hDEAD_BEEF_0000_1111_2222_3333_4444_5555, 3, 0, 1, 1);
    endtask

    task automatic t_hold;
        logic [127:0] prev;
        prev = dst_new;
        src_a = '1; src_b = '1; size = 2'd0;
        @(negedge clk);
        check("R8 no pulse", {127'd0, out_valid}, 128'd0);
        check("R9 hold", dst_new, prev);
    endtask

    task automatic t_alias;
        logic [127:0] v = 128'h0F0E_0D0C_0B0A_0908_0706_0504_0302_0100;
        run_op("R11 alias", v, 128'h1000_2000_3000_4000_5000_6000_7000_8000, v, 0, 0, 0, 1);
    endtask

    task automatic t_random;
        for (int k = 0; k < 40; k++)
            run_op("R1 R3 R4 R5 rand",
                   {$urandom, $urandom, $urandom, $urandom},
                   {$urandom, $urandom, $urandom, $urandom},
                   {$urandom, $urandom, $urandom, $urandom},
                   k % 3, k[0], k[1], k[2]);
    endtask

    initial begin
        rst_n = 1'b0; in_valid = 1'b0; src_a = '0; src_b = '0; dst_old = '0;
        size = '0; sub_en = 0; round_en = 0; upper_sel = 0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        t_reset();
        t_add_sizes();
        t_sub_borrow();
        t_round();
        t_halves();
        t_illegal();
        t_hold();
        t_alias();
        t_random();
        done = 1'b1;
        $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            n_tests++;
            n_fail++;
            $display("FAIL watchdog actual=timeout expected=finish");
            $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
            $finish;
        end
    end
endmodule